// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches one active-low external interrupt line and turns it into an interrupt request for a processor core. The line is first brought into the clock domain by a short flip-flop chain. A small control register then chooses how the line is read. In level mode the request follows the line while it is held low. In edge mode only a high-to-low transition counts, and it is held in a pending latch until the core acknowledges it. A local enable bit gates the request.

Level mode lets several open-drain sources share the one line, because the request stays up for as long as any of them pulls it low. Edge mode needs no control over how long a pulse lasts, but it reacts to every falling transition, including those caused by noise. The sensitivity bit is protected against careless rewrites. In normal operation it can be written only once after reset. In special (test) operation the first write after reset does not reach it, and every later write does. The enable bit has no such protection and takes every write.

Top module: `eirq_top`

## Requirements
- R1: With control bit 7 = 1 (edge mode), only a high-to-low transition of the synchronized line produces a request. A line that stays low after its request has been acknowledged produces no further request.
- R2: With control bit 6 = 0, `irq_req` stays 0 whatever the line does.
- R3: After reset `ctrl_q` reads 0x40: level mode, enabled. Bits 5..0 always read 0, whatever value was written to them.
- R4: With `special_mode` = 0, only the first write after reset changes bit 7. Later writes leave bit 7 unchanged.
- R5: With `special_mode` = 1, the first write after reset leaves bit 7 unchanged. Every later write loads bit 7.
- R6: Every write loads bit 6 from `wr_data[6]`, in both modes.
- R7: In level mode (bit 7 = 0) with the block enabled, `irq_req` is 1 from the second rising edge after `pin_n` goes low until the second rising edge after it goes high. `ack` has no effect in this mode.
- R8: In edge mode a falling transition raises `irq_req` at the third rising edge after the line falls. The request stays up after the line returns high, and it clears at the first rising edge where `ack` = 1.
- R9: When a new falling transition is detected in the same cycle as `ack`, the pending request stays set.
- R10: A falling transition that arrives while the block is disabled is still latched as pending. It appears on `irq_req` in the cycle after the enable bit is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| special_mode | input | 1 | 1 = special (test) operation, 0 = normal operation |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Write data: bit 7 = sensitivity, bit 6 = enable |
| pin_n | input | 1 | Raw active-low interrupt line |
| ack | input | 1 | Clears a pending edge request |
| ctrl_q | output | 8 | Current control register value |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The bound checker tests the register rules on every cycle: the value after reset, the zero bits, the enable bit loading on each write, the sensitivity bit staying put between writes, the normal-mode lock after the first write, and the special-mode first write that is ignored. It also checks on every cycle that a disabled block never raises a request. The pending latch cannot be seen at the ports, and neither can the falling-edge detector. Its behaviour therefore shows only in the bench's scenarios:
- the request persists after the line returns high;
- an acknowledge that coincides with a new edge leaves the request set;
- a line held low produces one request only;
- an edge latched while disabled shows up once the block is enabled again.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int REG_W     = 8;
  localparam int SENSE_BIT = 7;
  localparam int EN_BIT    = 6;
  localparam logic [REG_W-1:0] CTRL_RESET = 8'h40;

  typedef enum logic {
    SENSE_LEVEL = 1'b0,
    SENSE_FALL  = 1'b1
  } sense_e;
endpackage

// File: rtl/eirq_sync.sv
// Brings the raw line into the clock domain and flags falling transitions.
module eirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic pin_low,
  output logic fall
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      last  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], pin_n};
      last  <= chain[TOP];
    end
  end

  assign pin_low = ~chain[TOP];
  assign fall    = last & ~chain[TOP];
endmodule

// File: rtl/eirq_ctrl_reg.sv
// Control register with the write-protection rules on the sensitivity bit.
module eirq_ctrl_reg
  import eirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             special_mode,
  input  logic             wr_en,
  input  logic             wr_sense,
  input  logic             wr_enable,
  output sense_e           sense,
  output logic             enable,
  output logic [REG_W-1:0] ctrl_q
);
  logic wr_seen;
  logic sense_we;

  // Normal mode: only the first write lands. Special mode: only the first write is dropped.
  assign sense_we = wr_en & (special_mode ? wr_seen : ~wr_seen);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_seen <= 1'b0;
      sense   <= sense_e'(CTRL_RESET[SENSE_BIT]);
      enable  <= CTRL_RESET[EN_BIT];
    end else begin
      if (wr_en)    wr_seen <= 1'b1;
      if (sense_we) sense   <= sense_e'(wr_sense);
      if (wr_en)    enable  <= wr_enable;
    end
  end

  always_comb begin
    ctrl_q            = '0;
    ctrl_q[SENSE_BIT] = sense;
    ctrl_q[EN_BIT]    = enable;
  end
endmodule

// File: rtl/eirq_pend.sv
// Pending latch for edge mode and request gating.
module eirq_pend
  import eirq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  sense_e sense,
  input  logic   enable,
  input  logic   fall,
  input  logic   pin_low,
  input  logic   ack,
  output logic   irq_req
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= (sense == SENSE_FALL) & (fall | (pend & ~ack));
  end

  assign irq_req = enable & ((sense == SENSE_FALL) ? pend : pin_low);
endmodule

// File: rtl/eirq_top.sv
module eirq_top
  import eirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             special_mode,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             pin_n,
  input  logic             ack,
  output logic [REG_W-1:0] ctrl_q,
  output logic             irq_req
);
  sense_e sense;
  logic   enable;
  logic   pin_low;
  logic   fall;
  logic   unused_bits;

  assign unused_bits = ^wr_data[EN_BIT-1:0];

  eirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_n(pin_n), .pin_low(pin_low), .fall(fall)
  );

  eirq_ctrl_reg u_reg (
    .clk(clk), .rst(rst), .special_mode(special_mode), .wr_en(wr_en),
    .wr_sense(wr_data[SENSE_BIT]), .wr_enable(wr_data[EN_BIT]),
    .sense(sense), .enable(enable), .ctrl_q(ctrl_q)
  );

  eirq_pend u_pend (
    .clk(clk), .rst(rst), .sense(sense), .enable(enable), .fall(fall),
    .pin_low(pin_low), .ack(ack), .irq_req(irq_req)
  );
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk (
  input logic       clk,
  input logic       rst,
  input logic       special_mode,
  input logic       wr_en,
  input logic       wr_en_bit,
  input logic [7:0] ctrl_q,
  input logic       irq_req
);
  logic seen;

  always_ff @(posedge clk) begin
    if (rst)        seen <= 1'b0;
    else if (wr_en) seen <= 1'b1;
  end

  AST_RESET_VALUE: assert property (@(posedge clk) rst |=> (ctrl_q == 8'h40)); // R3
  AST_ZERO_BITS: assert property (@(posedge clk) disable iff (rst) ctrl_q[5:0] == 6'd0); // R3
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst) !ctrl_q[6] |-> !irq_req); // R2
  AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (rst) wr_en |=> (ctrl_q[6] == $past(wr_en_bit))); // R6
  AST_SENSE_HOLDS: assert property (@(posedge clk) disable iff (rst) !wr_en |=> $stable(ctrl_q[7])); // R4
  AST_NORMAL_LOCK: assert property (@(posedge clk) disable iff (rst) (seen && !special_mode && wr_en) |=> $stable(ctrl_q[7])); // R4
  AST_SPECIAL_FIRST: assert property (@(posedge clk) disable iff (rst) (!seen && special_mode && wr_en) |=> $stable(ctrl_q[7])); // R5
endmodule

bind eirq_top eirq_chk u_chk (
  .clk(clk), .rst(rst), .special_mode(special_mode), .wr_en(wr_en),
  .wr_en_bit(wr_data[6]), .ctrl_q(ctrl_q), .irq_req(irq_req)
);

// File: tb/eirq_top_test.sv
module eirq_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {reset first, special_mode, write data, expected ctrl_q}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'h80, 8'h80},  // R4 first write lands
    {1'b0, 1'b0, 8'h40, 8'hC0},  // R4 locked, R6 enable loads
    {1'b0, 1'b0, 8'h00, 8'h80},  // R4 R6
    {1'b0, 1'b0, 8'hFF, 8'hC0},  // R3 low bits read zero
    {1'b1, 1'b1, 8'hC0, 8'h40},  // R5 first write dropped
    {1'b0, 1'b1, 8'h80, 8'h80},  // R5 second write lands
    {1'b0, 1'b1, 8'h00, 8'h00},  // R5 R6
    {1'b0, 1'b1, 8'hC0, 8'hC0}   // R5
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       special_mode = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       pin_n = 1'b1;
  logic       ack = 1'b0;
  logic [7:0] ctrl_q;
  logic       irq_req;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eirq_top uut (
    .clk(clk), .rst(rst), .special_mode(special_mode), .wr_en(wr_en),
    .wr_data(wr_data), .pin_n(pin_n), .ack(ack), .ctrl_q(ctrl_q), .irq_req(irq_req)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; pin_n = 1'b1; ack = 1'b0; wr_en = 1'b0;
    step(3);
    rst = 1'b0;
  endtask

  task automatic wr(input logic spec, input logic [7:0] d);
    special_mode = spec; wr_data = d; wr_en = 1'b1;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    do_reset();
    step(1);
    chk("R3 reset ctrl", ctrl_q, 8'h40);
    chk("R3 reset irq", {7'd0, irq_req}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][17]) do_reset();
      wr(VEC[i][16], VEC[i][15:8]);
      chk("R4 R5 R6 table", ctrl_q, VEC[i][7:0]);
    end

    // Level mode
    do_reset();
    pin_n = 1'b0; step(1);
    chk("R7 not yet", {7'd0, irq_req}, 8'h00);
    step(1);
    chk("R7 level high", {7'd0, irq_req}, 8'h01);
    ack = 1'b1; step(1); ack = 1'b0;
    chk("R7 ack ignored", {7'd0, irq_req}, 8'h01);
    pin_n = 1'b1; step(2);
    chk("R7 released", {7'd0, irq_req}, 8'h00);
    wr(1'b0, 8'h00);
    pin_n = 1'b0; step(3);
    chk("R2 level masked", {7'd0, irq_req}, 8'h00);

    // Edge mode
    do_reset();
    wr(1'b0, 8'hC0);
    pin_n = 1'b0; step(3);
    chk("R8 edge raises", {7'd0, irq_req}, 8'h01);
    pin_n = 1'b1; step(3);
    chk("R8 persists", {7'd0, irq_req}, 8'h01);
    ack = 1'b1; step(1); ack = 1'b0;
    chk("R8 ack clears", {7'd0, irq_req}, 8'h00);
    pin_n = 1'b0; step(3);
    chk("R1 held low first", {7'd0, irq_req}, 8'h01);
    ack = 1'b1; step(1); ack = 1'b0;
    step(3);
    chk("R1 held low once", {7'd0, irq_req}, 8'h00);
    pin_n = 1'b1; step(3);
    pin_n = 1'b0; step(3);
    pin_n = 1'b1; step(3);
    pin_n = 1'b0; step(2);
    ack = 1'b1; step(1); ack = 1'b0;
    chk("R9 edge with ack", {7'd0, irq_req}, 8'h01);
    ack = 1'b1; step(1); ack = 1'b0;
    chk("R9 later ack", {7'd0, irq_req}, 8'h00);

    // Disabled then re-enabled
    wr(1'b0, 8'h80);
    pin_n = 1'b1; step(3);
    pin_n = 1'b0; step(3);
    chk("R2 edge masked", {7'd0, irq_req}, 8'h00);
    wr(1'b0, 8'hC0);
    chk("R10 pending shown", {7'd0, irq_req}, 8'h01);

    report();
  end
endmodule